// File: doc/BRIEF.md
# Bus Hold Timer

This block caps how long the local processor may keep ownership of a shared external bus while other processors are waiting for it. Software programs a hold limit through a small register port. Each time the processor acquires the bus, a down-counter loads that limit. The counter then counts down, but only in cycles in which the processor is actually moving data on the bus and at least one other master is asking for it. Once the count is used up, the block pulls the processor's outgoing bus-request line low for one cycle. This lets the arbiter hand the bus to someone else.

The limit is offset by two from the real budget. A limit of L allows L + 2 contended cycles of ownership, counted from the acquisition cycle. A limit of 0 switches the timer off. The value 1 is not legal: a write of 1 is stored as 2 and sets a sticky error flag. Whenever the outgoing request line is low, for any reason, the counter reloads from the limit. The arbitration itself and the data path sit outside this block.

All pins are plain control and status signals. The register port is a single-cycle write strobe with a combinational read mux, so there is no valid/ready stream and no back-pressure.

Top module: `bus_hold_timer`

## Requirements
- R1: After reset, the limit, the count and the error flag read 0, `force_release` is 0, and `req_out` equals `req_in`.
- R2: A write to address 0 stores `reg_wdata` as the limit. A written value of 1 is stored as 2 and sets the error flag, which reads as bit 0 at address 2. Writing address 2 with bit 0 set clears the flag. A legal write leaves the flag unchanged.
- R3: The count reads at address 1 and is read-only: a write to address 1 leaves it unchanged.
- R4: The counter loads the limit in the first cycle in which `bus_owned` is high after a cycle in which it was low. The loaded value is readable in the next cycle.
- R5: The counter decreases by one, as seen in the next cycle, only after a cycle with `bus_owned`, `bus_xfer` and `others_req` all high, a nonzero limit and a nonzero count. Otherwise it holds, unless R4 or R6 applies.
- R6: In any cycle in which `req_out` is low, the counter reloads from the limit; the new value is visible in the next cycle.
- R7: A qualifying cycle (as in R5) that finds the count at 0 and is not an acquisition cycle makes `force_release` high in the next cycle, for exactly one cycle, and the count then reloads. With limit L and contention from the acquisition cycle onward, `force_release` rises in the cycle after L + 2 owned cycles.
- R8: With the limit at 0, the count does not change on contended transfers, and `force_release` stays 0.
- R9: `req_out` equals `req_in` in every cycle except those in which `force_release` is high; in those cycles `req_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 limit, 1 count, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| bus_owned | input | 1 | Local processor currently holds the bus |
| bus_xfer | input | 1 | Local processor performs a bus read or write this cycle |
| others_req | input | 1 | At least one other master requests the bus |
| req_in | input | 1 | Bus request from the local processor |
| req_out | output | 1 | Bus request driven to the arbiter |
| force_release | output | 1 | One-cycle pulse: hold time exhausted, request forced low |

## Verification
The count is driven with transfers alone, contention alone and both together. This shows that only the combination of transfer and contention consumes budget. A request drop in the middle of a count separates a reload on request loss from an ordinary decrement. A zero limit checks that the timer stays silent under contention. A run with limit 2 from a fresh acquisition pins down the two-cycle offset exactly. Register writes of 1, of a legal value and to the read-only count cover the illegal-value mapping, the sticky flag and the write protection.

// File: rtl/bht_pkg.sv
package bht_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;

  typedef enum logic {ST_RUN = 1'b0, ST_DROP = 1'b1} rel_st_e;
endpackage

// File: rtl/bht_regs.sv
module bht_regs
  import bht_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cnt,
  output logic [W-1:0]      lim,
  output logic              err,
  output logic [W-1:0]      rdata
);
  localparam logic [W-1:0] ILLEGAL = W'(1);
  localparam logic [W-1:0] MIN_OK  = W'(2);

  logic bad_wr;
  assign bad_wr = wr && (addr == ADDR_LIMIT) && (wdata == ILLEGAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim <= '0;
      err <= 1'b0;
    end else begin
      if (wr && addr == ADDR_LIMIT)
        lim <= bad_wr ? MIN_OK : wdata;
      if (bad_wr)
        err <= 1'b1;
      else if (wr && addr == ADDR_STAT && wdata[0])
        err <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      ADDR_LIMIT: rdata = lim;
      ADDR_COUNT: rdata = cnt;
      ADDR_STAT:  rdata = {{(W-1){1'b0}}, err};
      default:    rdata = '0;
    endcase
  end

  p_limit_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lim != ILLEGAL);

  p_bad_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> (err && lim == MIN_OK));
endmodule

// File: rtl/bht_counter.sv
module bht_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lim,
  input  logic         owned,
  input  logic         xfer,
  input  logic         others,
  input  logic         req_eff,
  output logic [W-1:0] cnt,
  output logic         expired
);
  logic owned_q;
  logic acq;
  logic qual;

  assign acq     = owned && !owned_q;
  assign qual    = owned && xfer && others && (lim != '0);
  assign expired = qual && (cnt == '0) && !acq && req_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owned_q <= 1'b0;
      cnt     <= '0;
    end else begin
      owned_q <= owned;
      if (!req_eff)
        cnt <= lim;
      else if (acq)
        cnt <= lim;
      else if (qual && cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_eff |=> cnt == $past(lim));

  p_acq_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_eff && acq) |=> cnt == $past(lim));

  p_dec_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_eff && !acq && qual && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_eff && !acq && !qual) |=> $stable(cnt));
endmodule

// File: rtl/bht_release.sv
module bht_release
  import bht_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expired,
  input  logic req_in,
  output logic force_release,
  output logic req_out
);
  rel_st_e st;

  always_ff @(posedge clk) begin
    if (!rst_n)
      st <= ST_RUN;
    else if (st == ST_RUN && expired)
      st <= ST_DROP;
    else
      st <= ST_RUN;
  end

  assign force_release = (st == ST_DROP);
  assign req_out       = req_in && !force_release;

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_release |=> !force_release);

  p_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !force_release) |=> force_release);

  p_req_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_release |-> !req_out);
endmodule

// File: rtl/bus_hold_timer.sv
module bus_hold_timer
  import bht_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              bus_owned,
  input  logic              bus_xfer,
  input  logic              others_req,
  input  logic              req_in,
  output logic              req_out,
  output logic              force_release
);
  logic [W-1:0] lim;
  logic [W-1:0] cnt;
  logic         err;
  logic         expired;

  bht_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cnt(cnt), .lim(lim), .err(err), .rdata(reg_rdata)
  );

  bht_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .lim(lim), .owned(bus_owned),
    .xfer(bus_xfer), .others(others_req), .req_eff(req_out),
    .cnt(cnt), .expired(expired)
  );

  bht_release u_rel (
    .clk(clk), .rst_n(rst_n), .expired(expired), .req_in(req_in),
    .force_release(force_release), .req_out(req_out)
  );

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_release |-> $past(lim) != '0);
endmodule

// File: tb/sim_bus_hold_timer.sv
`timescale 1ns/1ps
module sim_bus_hold_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bus_owned = 1'b0;
  logic        bus_xfer = 1'b0;
  logic        others_req = 1'b0;
  logic        req_in = 1'b1;
  logic        req_out;
  logic        force_release;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  bus_hold_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_owned(bus_owned),
    .bus_xfer(bus_xfer), .others_req(others_req), .req_in(req_in),
    .req_out(req_out), .force_release(force_release)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rd(input logic [15:0] v, input string tag);
    sb.push_back('{0, v, tag});
  endtask

  task automatic expect_force(input logic v, input string tag);
    sb.push_back('{1, {15'd0, v}, tag});
  endtask

  task automatic expect_req(input logic v, input string tag);
    sb.push_back('{2, {15'd0, v}, tag});
  endtask

  task automatic write(input logic [1:0] a, input logic [15:0] d);
    step();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #4;
      while (sb.size() > 0) begin
        exp_t e;
        logic [15:0] act;
        e = sb.pop_front();
        case (e.kind)
          0: act = reg_rdata;
          1: act = {15'd0, force_release};
          default: act = {15'd0, req_out};
        endcase
        checks++;
        if (act !== e.val) begin
          errors++;
          $display("FAIL %s kind=%0d got %0h expected %0h", e.tag, e.kind, act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1; reg_addr = 2'd0;
    expect_rd(16'd0, "R1 limit"); expect_force(1'b0, "R1 force"); expect_req(1'b1, "R1 req");
    step(); reg_addr = 2'd1; expect_rd(16'd0, "R1 count");
    step(); reg_addr = 2'd2; expect_rd(16'd0, "R1 err");

    // R2: illegal limit 1 maps to 2 and sets the flag
    write(2'd0, 16'd1);
    reg_addr = 2'd0; expect_rd(16'd2, "R2 limit 1->2");
    step(); reg_addr = 2'd2; expect_rd(16'd1, "R2 err set");
    write(2'd2, 16'd1);
    reg_addr = 2'd2; expect_rd(16'd0, "R2 err clear");

    // R3: count is read-only
    write(2'd1, 16'h0055);
    reg_addr = 2'd1; expect_rd(16'd0, "R3 count ro");

    write(2'd0, 16'd3);
    reg_addr = 2'd0; expect_rd(16'd3, "R2 limit 3");
    step(); reg_addr = 2'd2; expect_rd(16'd0, "R2 err kept");

    // R4: acquisition loads the limit
    step(); reg_addr = 2'd1; bus_owned = 1'b1;
    step(); expect_rd(16'd3, "R4 load");
    bus_xfer = 1'b1; others_req = 1'b0;
    step(); expect_rd(16'd3, "R5 xfer only");
    bus_xfer = 1'b0; others_req = 1'b1;
    step(); expect_rd(16'd3, "R5 others only");
    bus_xfer = 1'b1; others_req = 1'b1;
    step(); expect_rd(16'd2, "R5 dec");
    step(); expect_rd(16'd1, "R5 dec");
    step(); expect_rd(16'd0, "R5 dec"); expect_force(1'b0, "R7 not yet");
    step(); expect_force(1'b1, "R7 force"); expect_req(1'b0, "R9 req low"); expect_rd(16'd0, "R7 cnt");
    step(); expect_force(1'b0, "R7 pulse"); expect_req(1'b1, "R9 req back"); expect_rd(16'd3, "R7 reload");

    // R6: request drop reloads
    step(); req_in = 1'b0; expect_req(1'b0, "R9 follow"); expect_rd(16'd2, "R6 pre");
    step(); req_in = 1'b1; expect_req(1'b1, "R9 follow"); expect_rd(16'd3, "R6 reload");

    // R8: limit 0 disables
    step(); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'd0; bus_xfer = 1'b0;
    step(); reg_wr = 1'b0; reg_addr = 2'd1; req_in = 1'b0;
    step(); req_in = 1'b1; bus_xfer = 1'b1; others_req = 1'b1;
    expect_rd(16'd0, "R8 cnt zero");
    for (int i = 0; i < 8; i++) begin
      step(); expect_force(1'b0, "R8 no force"); expect_rd(16'd0, "R8 cnt hold");
    end

    // R7 budget: limit 2 gives 4 owned contended cycles
    step(); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'd2;
    bus_owned = 1'b0; bus_xfer = 1'b0; others_req = 1'b0;
    step(); reg_wr = 1'b0; reg_addr = 2'd1;
    step(); bus_owned = 1'b1; bus_xfer = 1'b1; others_req = 1'b1;
    step(); expect_rd(16'd2, "R7 budget t1");
    step(); expect_rd(16'd1, "R7 budget t2");
    step(); expect_rd(16'd0, "R7 budget t3"); expect_force(1'b0, "R7 budget t3");
    step(); expect_force(1'b1, "R7 budget t4"); expect_req(1'b0, "R9 budget t4");
    step(); expect_force(1'b0, "R7 budget t5");

    step(); step();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule